// File: doc/BRIEF.md
# I2C Line Conditioner and Bus Timing Monitor

This block takes the raw clock and data lines of an I2C bus, brings them into the system clock domain and removes short glitches. The cleaned levels feed the protocol logic downstream, together with one-cycle strobes for clock edges and for START, repeated START and STOP conditions.

Every bus interval that has a minimum is counted in system clock cycles, from one cleaned edge or condition to the next. Each minimum is a parameter. When an interval comes up short, the block sets a sticky bit for that class of interval and records a code for the most recent offence. Software or protocol logic reads the flags and clears them with a one-cycle clear pulse.

The block shifts no bytes and drives no bus line. The lines are treated as inputs only.

Top module: `i2c_line_monitor`

## Requirements
- R1: Each line passes through a two-stage synchronizer and then a filter. The filtered level takes a new value only after the synchronized line has held that value for 3 consecutive cycles. A pulse shorter than 3 cycles on either line changes no filtered level and raises no strobe. Both filtered levels are 1 after reset.
- R2: A falling edge of filtered data while filtered clock is steadily high gives a one-cycle `start_o` strobe. A rising edge of filtered data under the same condition gives a one-cycle `stop_o` strobe. When a START arrives between an earlier START and its STOP, `rep_start_o` is also raised.
- R3: A data edge in the same cycle as a falling clock edge is a zero hold time. It is accepted: it raises no condition strobe and no violation.
- R4: A clock low phase (fall to rise) shorter than 16 cycles sets `viol_o[0]`.
- R5: A clock high phase (rise to fall) shorter than 14 cycles sets `viol_o[1]`.
- R6: The interval from a START or repeated START to the next clock fall sets `viol_o[2]` when it is shorter than 14 cycles.
- R7: The interval from a clock rise to a repeated START sets `viol_o[3]` when it is shorter than 14 cycles.
- R8: The interval from a clock rise to a STOP sets `viol_o[4]` when it is shorter than 14 cycles.
- R9: The interval from a STOP to the next non-repeated START sets `viol_o[5]` when it is shorter than 14 cycles.
- R10: The interval from a data edge to the next clock rise sets `viol_o[6]` when it is shorter than 8 cycles.
- R11: `code_o` is 0 after reset and after a clear. In any cycle that raises a violation, `code_o` takes 1 plus the lowest bit index raised in that cycle.
- R12: Violation bits stay set until a cycle with `clr_i` high. That cycle drops all old bits but keeps any violation raised in the same cycle.
- R13: Interval counters are 8 bits wide by default and saturate instead of wrapping. A bus free time of 261 cycles therefore raises no bus-free violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clears sticky violation bits and the code |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| scl_o | output | 1 | Filtered clock level |
| sda_o | output | 1 | Filtered data level |
| start_o | output | 1 | START or repeated START strobe |
| rep_start_o | output | 1 | Repeated START strobe |
| stop_o | output | 1 | STOP strobe |
| scl_rise_o | output | 1 | Filtered clock rising edge strobe |
| scl_fall_o | output | 1 | Filtered clock falling edge strobe |
| viol_o | output | 7 | Sticky violation bits, one per interval class |
| code_o | output | 3 | Code of the most recent violation |

## Verification
A complete transfer drives the lines: START, one data clock, an optional repeated START, a second clock, then STOP. One interval at a time is swept from three cycles below its limit to three cycles above it, so an off-by-one in any comparison or any counter shows up as a wrong bit or code. Spike widths from 1 to 5 cycles on each line separate pulses that are filtered out from pulses that pass. A data edge placed exactly on the clock fall separates an accepted zero hold time from a false condition. Further cases cover an idle gap longer than the counter range, and the sticky bits together with their clear.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int NUM_VCLASS = 7;

    // violation class bit positions
    localparam int VI_SCL_LOW       = 0;
    localparam int VI_SCL_HIGH      = 1;
    localparam int VI_START_HOLD    = 2;
    localparam int VI_RESTART_SETUP = 3;
    localparam int VI_STOP_SETUP    = 4;
    localparam int VI_BUS_FREE      = 5;
    localparam int VI_DATA_SETUP    = 6;

    localparam int NUM_IVL = 4;
    localparam int IVL_SCL   = 0;
    localparam int IVL_SDA   = 1;
    localparam int IVL_START = 2;
    localparam int IVL_STOP  = 3;

    typedef enum logic [2:0] {
        VC_NONE          = 3'd0,
        VC_SCL_LOW       = 3'd1,
        VC_SCL_HIGH      = 3'd2,
        VC_START_HOLD    = 3'd3,
        VC_RESTART_SETUP = 3'd4,
        VC_STOP_SETUP    = 3'd5,
        VC_BUS_FREE      = 3'd6,
        VC_DATA_SETUP    = 3'd7
    } vcode_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_rise;
        logic sda_fall;
        logic start;
        logic rstart;
        logic stop;
    } bus_ev_t;

    typedef logic [NUM_VCLASS-1:0] vvec_t;

    // the interval ending now spans cnt+1 cycles
    function automatic logic too_short(input int unsigned cnt, input int unsigned min_c);
        return (cnt + 1) < min_c;
    endfunction

    function automatic vcode_e first_code(input vvec_t v);
        vcode_e r;
        r = VC_NONE;
        for (int i = NUM_VCLASS - 1; i >= 0; i--) begin
            if (v[i]) r = vcode_e'(3'(i + 1));
        end
        return r;
    endfunction

endpackage

// File: rtl/i2cmon_glitch_filter.sv
module i2cmon_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HCW = $clog2(HOLD_CYC + 1);
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_q;
    logic                   lvl_d;
    logic [HCW-1:0]         dwell_q;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= 1'b1;
            dwell_q <= '0;
        end else if (sync_out != lvl_q) begin
            if (dwell_q == HOLD_LAST) begin
                lvl_q   <= sync_out;
                dwell_q <= '0;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end else begin
            dwell_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b1;
        else     lvl_d <= lvl_q;
    end

    assign lvl_o  = lvl_q;
    assign rise_o = lvl_q & ~lvl_d;
    assign fall_o = ~lvl_q & lvl_d;

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_lvl_i,
    input  logic    scl_rise_i,
    input  logic    scl_fall_i,
    input  logic    sda_rise_i,
    input  logic    sda_fall_i,
    output bus_ev_t ev_o,
    output logic    busy_o
);
    logic busy_q;
    logic scl_steady_hi;

    // clock high both now and in the previous filtered cycle
    assign scl_steady_hi = scl_lvl_i & ~scl_rise_i;

    always_comb begin
        ev_o          = '0;
        ev_o.scl_rise = scl_rise_i;
        ev_o.scl_fall = scl_fall_i;
        ev_o.sda_rise = sda_rise_i;
        ev_o.sda_fall = sda_fall_i;
        ev_o.start    = sda_fall_i & scl_steady_hi;
        ev_o.stop     = sda_rise_i & scl_steady_hi;
        ev_o.rstart   = ev_o.start & busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst)             busy_q <= 1'b0;
        else if (ev_o.start) busy_q <= 1'b1;
        else if (ev_o.stop)  busy_q <= 1'b0;
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/i2cmon_ivl_ctr.sv
module i2cmon_ivl_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // starts saturated so the bus counts as long idle after reset
    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= CNT_MAX;
        else if (restart_i)        cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/i2cmon_timing_chk.sv
module i2cmon_timing_chk
    import i2cmon_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LOW_MIN      = 16,
    parameter int HIGH_MIN     = 14,
    parameter int START_HOLD   = 14,
    parameter int RESTART_SU   = 14,
    parameter int STOP_SU      = 14,
    parameter int BUS_FREE     = 14,
    parameter int DATA_SU      = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_i,
    input  bus_ev_t ev_i,
    output vvec_t   nv_o,
    output vvec_t   viol_o,
    output vcode_e  code_o
);
    logic [NUM_IVL-1:0] restart;
    logic [CNT_W-1:0]   ivl [NUM_IVL];
    logic               hold_pend_q;
    vvec_t              nv;
    vvec_t              viol_q;
    vcode_e             code_q;

    assign restart[IVL_SCL]   = ev_i.scl_rise | ev_i.scl_fall;
    assign restart[IVL_SDA]   = ev_i.sda_rise | ev_i.sda_fall;
    assign restart[IVL_START] = ev_i.start;
    assign restart[IVL_STOP]  = ev_i.stop;

    for (genvar g = 0; g < NUM_IVL; g++) begin : g_ivl
        i2cmon_ivl_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .restart_i (restart[g]),
            .cnt_o     (ivl[g])
        );
    end

    // a START waits for its first clock fall
    always_ff @(posedge clk) begin
        if (rst)                               hold_pend_q <= 1'b0;
        else if (ev_i.start)                   hold_pend_q <= 1'b1;
        else if (ev_i.scl_fall || ev_i.stop)   hold_pend_q <= 1'b0;
    end

    always_comb begin
        nv = '0;
        nv[VI_SCL_LOW]       = ev_i.scl_rise &
                               too_short(32'(ivl[IVL_SCL]), LOW_MIN);
        nv[VI_SCL_HIGH]      = ev_i.scl_fall &
                               too_short(32'(ivl[IVL_SCL]), HIGH_MIN);
        nv[VI_START_HOLD]    = ev_i.scl_fall & hold_pend_q &
                               too_short(32'(ivl[IVL_START]), START_HOLD);
        nv[VI_RESTART_SETUP] = ev_i.rstart &
                               too_short(32'(ivl[IVL_SCL]), RESTART_SU);
        nv[VI_STOP_SETUP]    = ev_i.stop &
                               too_short(32'(ivl[IVL_SCL]), STOP_SU);
        nv[VI_BUS_FREE]      = ev_i.start & ~ev_i.rstart &
                               too_short(32'(ivl[IVL_STOP]), BUS_FREE);
        nv[VI_DATA_SETUP]    = ev_i.scl_rise &
                               too_short(32'(ivl[IVL_SDA]), DATA_SU);
    end

    always_ff @(posedge clk) begin
        if (rst)        viol_q <= '0;
        else if (clr_i) viol_q <= nv;
        else            viol_q <= viol_q | nv;
    end

    always_ff @(posedge clk) begin
        if (rst)            code_q <= VC_NONE;
        else if (nv != '0)  code_q <= first_code(nv);
        else if (clr_i)     code_q <= VC_NONE;
    end

    assign nv_o   = nv;
    assign viol_o = viol_q;
    assign code_o = code_q;

endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3,
    parameter int CNT_W       = 8,
    parameter int LOW_MIN     = 16,
    parameter int HIGH_MIN    = 14,
    parameter int START_HOLD  = 14,
    parameter int RESTART_SU  = 14,
    parameter int STOP_SU     = 14,
    parameter int BUS_FREE    = 14,
    parameter int DATA_SU     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_o,
    output logic       start_o,
    output logic       rep_start_o,
    output logic       stop_o,
    output logic       scl_rise_o,
    output logic       scl_fall_o,
    output logic [6:0] viol_o,
    output logic [2:0] code_o
);
    localparam int NLINE = 2;
    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] lvl;
    logic [NLINE-1:0] rise;
    logic [NLINE-1:0] fall;
    bus_ev_t          ev;
    logic             busy;
    vvec_t            nv;
    vvec_t            viol;
    vcode_e           code;

    assign raw[LN_SCL] = scl_i;
    assign raw[LN_SDA] = sda_i;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2cmon_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYC    (FILT_CYC)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    i2cmon_cond_detect u_cond (
        .clk        (clk),
        .rst        (rst),
        .scl_lvl_i  (lvl[LN_SCL]),
        .scl_rise_i (rise[LN_SCL]),
        .scl_fall_i (fall[LN_SCL]),
        .sda_rise_i (rise[LN_SDA]),
        .sda_fall_i (fall[LN_SDA]),
        .ev_o       (ev),
        .busy_o     (busy)
    );

    i2cmon_timing_chk #(
        .CNT_W      (CNT_W),
        .LOW_MIN    (LOW_MIN),
        .HIGH_MIN   (HIGH_MIN),
        .START_HOLD (START_HOLD),
        .RESTART_SU (RESTART_SU),
        .STOP_SU    (STOP_SU),
        .BUS_FREE   (BUS_FREE),
        .DATA_SU    (DATA_SU)
    ) u_tchk (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .ev_i   (ev),
        .nv_o   (nv),
        .viol_o (viol),
        .code_o (code)
    );

    assign scl_o       = lvl[LN_SCL];
    assign sda_o       = lvl[LN_SDA];
    assign start_o     = ev.start;
    assign rep_start_o = ev.rstart;
    assign stop_o      = ev.stop;
    assign scl_rise_o  = ev.scl_rise;
    assign scl_fall_o  = ev.scl_fall;
    assign viol_o      = viol;
    assign code_o      = code;

endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr_i,
    input logic       scl_o,
    input logic       sda_o,
    input logic       start_o,
    input logic       rep_start_o,
    input logic       stop_o,
    input logic       scl_fall_o,
    input logic [6:0] viol_o,
    input logic [2:0] code_o,
    input logic [6:0] nv
);
    a_r1_scl_dwell: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_o) |=> $stable(scl_o) ##1 $stable(scl_o));

    a_r1_sda_dwell: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_o) |=> $stable(sda_o) ##1 $stable(sda_o));

    a_r2_cond_scl_high: assert property (@(posedge clk) disable iff (rst)
        (start_o || stop_o) |-> scl_o);

    a_r2_cond_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, stop_o}));

    a_r2_rstart_is_start: assert property (@(posedge clk) disable iff (rst)
        rep_start_o |-> start_o);

    a_r3_fall_no_cond: assert property (@(posedge clk) disable iff (rst)
        scl_fall_o |-> !(start_o || stop_o));

    a_r11_code_in_flags: assert property (@(posedge clk) disable iff (rst)
        (code_o != 3'd0) |-> viol_o[code_o - 3'd1]);

    a_r11_code_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (viol_o == 7'd0) |-> (code_o == 3'd0));

    a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((viol_o & ~$past(nv)) == 7'd0));

endmodule

bind i2c_line_monitor i2cmon_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr_i),
    .scl_o       (scl_o),
    .sda_o       (sda_o),
    .start_o     (start_o),
    .rep_start_o (rep_start_o),
    .stop_o      (stop_o),
    .scl_fall_o  (scl_fall_o),
    .viol_o      (viol_o),
    .code_o      (code_o),
    .nv          (nv)
);

// File: tb/sim_i2c_line_monitor.sv
`timescale 1ns/1ps
module sim_i2c_line_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       scl_o, sda_o, start_o, rep_start_o, stop_o, scl_rise_o, scl_fall_o;
    logic [6:0] viol_o;
    logic [2:0] code_o;

    int n_vec  = 0;
    int n_miss = 0;
    int c_start = 0, c_rstart = 0, c_stop = 0, c_fall = 0;

    always #5 clk = ~clk;

    i2c_line_monitor u0 (
        .clk(clk), .rst(rst), .clr_i(clr), .scl_i(scl), .sda_i(sda),
        .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .rep_start_o(rep_start_o),
        .stop_o(stop_o), .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o),
        .viol_o(viol_o), .code_o(code_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            c_start  = c_start  + int'(start_o);
            c_rstart = c_rstart + int'(rep_start_o);
            c_stop   = c_stop   + int'(stop_o);
            c_fall   = c_fall   + int'(scl_fall_o);
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_miss++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        hold(1);
        clr = 1'b0;
    endtask

    // one transfer; ends in the cycle its STOP is driven
    task automatic txn(input int b, input int hd, input int lo, input int su,
                       input int hi, input bit rs, input int sto);
        scl = 1'b1; sda = 1'b1; hold(b);
        sda = 1'b0; hold(hd);
        scl = 1'b0;
        if (su == lo) begin
            sda = 1'b1; hold(lo);
        end else begin
            hold(lo - su); sda = 1'b1; hold(su);
        end
        scl = 1'b1; hold(hi);
        if (rs) begin
            sda = 1'b0; hold(20);
        end
        scl = 1'b0; hold(5); sda = 1'b0; hold(15);
        scl = 1'b1; hold(sto); sda = 1'b1;
    endtask

    function automatic int exp_viol(input int b, input int hd, input int lo, input int su,
                                    input int hi, input bit rs, input int sto);
        int v;
        v = 0;
        if (lo < 16)         v |= 1;   // R4
        if (!rs && hi < 14)  v |= 2;   // R5
        if (hd < 14)         v |= 4;   // R6
        if (rs && hi < 14)   v |= 8;   // R7
        if (sto < 14)        v |= 16;  // R8
        if (b < 14)          v |= 32;  // R9
        if (su < 8)          v |= 64;  // R10
        return v;
    endfunction

    function automatic int exp_code(input int v);
        for (int i = 0; i < 7; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    task automatic run_vec(input string tag, input int b, input int hd, input int lo,
                           input int su, input int hi, input bit rs, input int sto);
        int ev;
        pulse_clear();
        txn(20, 20, 20, 10, 20, 1'b0, 20);
        txn(b, hd, lo, su, hi, rs, sto);
        hold(12);
        ev = exp_viol(b, hd, lo, su, hi, rs, sto);
        check({tag, " viol"}, int'(viol_o), ev);
        check({tag, " code R11"}, int'(code_o), exp_code(ev));
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin : main
        int s0, s1, s2, s3;
        hold(3);
        rst = 1'b0;
        hold(1);
        // R1 R12 reset state
        check("R1 reset scl", int'(scl_o), 1);
        check("R1 reset sda", int'(sda_o), 1);
        check("R12 reset viol", int'(viol_o), 0);
        check("R11 reset code", int'(code_o), 0);
        hold(20);

        // R2 plain transfer and repeated START transfer
        s0 = c_start; s1 = c_stop; s2 = c_rstart;
        txn(20, 20, 20, 10, 20, 1'b0, 20); hold(12);
        check("R2 start count", c_start - s0, 1);
        check("R2 stop count", c_stop - s1, 1);
        check("R2 rstart none", c_rstart - s2, 0);
        check("R2 nominal viol", int'(viol_o), 0);
        s0 = c_start; s2 = c_rstart;
        txn(20, 20, 20, 10, 20, 1'b1, 20); hold(12);
        check("R2 rs start count", c_start - s0, 2);
        check("R2 rs rstart count", c_rstart - s2, 1);
        check("R2 rs viol", int'(viol_o), 0);

        // interval sweeps, three below to three above each limit
        for (int d = -3; d <= 3; d++) run_vec("R4 low",     20, 20, 16 + d, 10, 20, 1'b0, 20);
        for (int d = -3; d <= 3; d++) run_vec("R5 high",    20, 20, 20, 10, 14 + d, 1'b0, 20);
        for (int d = -3; d <= 3; d++) run_vec("R6 hold",    20, 14 + d, 20, 10, 20, 1'b0, 20);
        for (int d = -3; d <= 3; d++) run_vec("R7 rsetup", 20, 20, 20, 10, 14 + d, 1'b1, 20);
        for (int d = -3; d <= 3; d++) run_vec("R8 psetup", 20, 20, 20, 10, 20, 1'b0, 14 + d);
        for (int d = -3; d <= 3; d++) run_vec("R9 free",   14 + d, 20, 20, 10, 20, 1'b0, 20);
        for (int d = -3; d <= 3; d++) run_vec("R10 dsetup", 20, 20, 20, 8 + d, 20, 1'b0, 20);

        // R3 data edge on the clock fall
        pulse_clear();
        s0 = c_start; s1 = c_stop;
        txn(20, 20, 20, 20, 20, 1'b0, 20); hold(12);
        check("R3 zero hold viol", int'(viol_o), 0);
        check("R3 zero hold starts", c_start - s0, 1);
        check("R3 zero hold stops", c_stop - s1, 1);

        // R13 idle longer than counter range
        run_vec("R13 long idle", 261, 20, 20, 10, 20, 1'b0, 20);

        // R1 spike widths on each line
        for (int w = 1; w <= 5; w++) begin
            pulse_clear();
            hold(20);
            s0 = c_start; s1 = c_stop;
            sda = 1'b0; hold(w); sda = 1'b1; hold(20);
            check("R1 sda spike start", c_start - s0, (w >= 3) ? 1 : 0);
            check("R1 sda spike stop", c_stop - s1, (w >= 3) ? 1 : 0);
            s3 = c_fall;
            scl = 1'b0; hold(w); scl = 1'b1; hold(20);
            check("R1 scl spike fall", c_fall - s3, (w >= 3) ? 1 : 0);
            check("R1 scl spike viol", int'(viol_o), (w >= 3) ? 1 : 0);
        end

        // R12 sticky and clear
        pulse_clear();
        hold(20);
        txn(20, 20, 20, 10, 20, 1'b0, 10); hold(12);
        check("R12 stop setup set", int'(viol_o), 16);
        check("R11 stop setup code", int'(code_o), 5);
        txn(20, 20, 20, 10, 20, 1'b0, 20); hold(12);
        check("R12 sticky kept", int'(viol_o), 16);
        pulse_clear();
        hold(2);
        check("R12 cleared", int'(viol_o), 0);
        check("R11 code cleared", int'(code_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule